// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written over an 8-bit parallel port into asynchronous serial frames. A byte is captured on the falling edge of an active-low write strobe into a holding register. As soon as the serializer is free, the byte is copied into a separate shift register and the frame starts. The frame is a low start bit, the eight data bits least significant first, an optional parity bit and a high stop bit. Bit timing comes from an external enable pulse at sixteen times the bit rate, and each bit lasts sixteen of those pulses.

The holding register and the shift register are separate, so software can queue the next byte while the current frame is still going out. When a byte is waiting at the end of a stop bit, the next start bit follows in the same clock cycle. Two status outputs are provided. One shows that the serializer is empty, and the other shows that the holding register is occupied. A write that arrives while the holding register is occupied is dropped.

The state machine has five states: IDLE, START, DATA, PARITY and STOP. The transitions are:
- IDLE to START when the holding register is full (this is the transfer).
- START to DATA after one bit time.
- DATA to PARITY or to STOP after the eighth data bit. It goes to PARITY when parity is enabled.
- PARITY to STOP after one bit time.
- STOP to START when a byte is waiting, otherwise STOP to IDLE.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `sdo` is 1, `tx_empty` is 1 and `hold_full` is 0.
- R2: A falling edge on `wr_n` while `hold_full` is 0 stores `din` in the holding register. `hold_full` is 1 in the following cycle.
- R3: While idle with the holding register full, the byte moves to the shift register in one cycle. In the next cycle `hold_full` is 0, `tx_empty` is 0 and `sdo` is 0, which is the start bit.
- R4: A frame is sent in this order:
  - a start bit of 0;
  - data bits 0 through 7, least significant bit first;
  - a parity bit, only when `par_en` is 1;
  - a stop bit of 1.
- R5: Every bit of the frame lasts exactly 16 pulses of `tick16`. `sdo` changes while busy only in a cycle that follows a `tick16` pulse.
- R6: The parity bit is the XOR of the 8 data bits when `par_odd` is 0 (even parity). It is the inverse of that XOR when `par_odd` is 1 (odd parity). `par_en` and `par_odd` are sampled at the transfer.
- R7: If the holding register is full when a stop bit ends, the next start bit begins in the same cycle and `tx_empty` stays 0.
- R8: When a stop bit ends with the holding register empty, `tx_empty` returns to 1. `sdo` is 1 whenever `tx_empty` is 1.
- R9: A write that arrives while `hold_full` is 1 is ignored. The queued byte is the one that is sent.
- R10: Holding `wr_n` low for many cycles loads the holding register only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable pulse at 16 times the bit rate |
| din | input | 8 | Parallel byte to send |
| wr_n | input | 1 | Active-low write strobe; acts on its falling edge |
| par_en | input | 1 | 1 inserts a parity bit |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| sdo | output | 1 | Serial data line, high when idle |
| tx_empty | output | 1 | 1 when no frame is being shifted out |
| hold_full | output | 1 | 1 when a byte waits in the holding register |

## Verification
Suppose the bit counter or the bit index is wrong. The fault then shows up on `sdo` within one frame, as a misplaced parity or stop bit, a shifted data byte, or a start bit that is not 16 ticks long. Suppose instead the holding-register flag is wrong. That fault shows one or two cycles after a write, either as a lost or duplicated frame or as `hold_full` and `tx_empty` disagreeing with the expected sequence. A missing back-to-back transfer shows as an idle gap at the frame boundary, visible in the same cycle that the stop bit ends.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;
endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd,
    output logic              par
);
    assign par = (^data) ^ odd;
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    input  logic              xfer,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    logic wr_q;
    logic wr_evt;

    // falling edge of the strobe, so a long low level counts once
    assign wr_evt = wr_q & ~wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            full <= 1'b0;
            data <= '0;
        end else begin
            wr_q <= wr_n;
            if (xfer) begin
                full <= 1'b0;
            end else if (wr_evt && !full) begin
                full <= 1'b1;
                data <= din;
            end
        end
    end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              par_en,
    input  logic              par_bit,
    output logic              xfer,
    output logic              sdo,
    output logic              busy
);
    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_t         st_q, st_d;
    logic [CNT_W-1:0]  tcnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              pen_q;
    logic              bit_end;

    assign bit_end = tick && (tcnt_q == CNT_TOP);

    // next state and transfer request
    always_comb begin
        st_d = st_q;
        xfer = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (hold_full) begin
                    st_d = ST_START;
                    xfer = 1'b1;
                end
            end
            ST_START: begin
                if (bit_end) st_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && idx_q == IDX_LAST) st_d = pen_q ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (bit_end) st_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (hold_full) begin
                        st_d = ST_START;
                        xfer = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            tcnt_q  <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            pen_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (xfer) begin
                shreg_q <= hold_data;
                par_q   <= par_bit;
                pen_q   <= par_en;
                tcnt_q  <= '0;
                idx_q   <= '0;
            end else if (tick && st_q != ST_IDLE) begin
                tcnt_q <= (tcnt_q == CNT_TOP) ? '0 : tcnt_q + 1'b1;
                if (bit_end && st_q == ST_DATA) begin
                    shreg_q <= shreg_q >> 1;
                    idx_q   <= idx_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sdo  = 1'b1;
        busy = 1'b1;
        unique case (st_q)
            ST_IDLE: begin
                sdo  = 1'b1;
                busy = 1'b0;
            end
            ST_START:  sdo = 1'b0;
            ST_DATA:   sdo = shreg_q[0];
            ST_PARITY: sdo = par_q;
            ST_STOP:   sdo = 1'b1;
            default: begin
                sdo  = 1'b1;
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_n,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              sdo,
    output logic              tx_empty,
    output logic              hold_full
);
    logic              xfer;
    logic              busy;
    logic              par_bit;
    logic [DATA_W-1:0] hold_q;

    uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_n  (wr_n),
        .din   (din),
        .xfer  (xfer),
        .full  (hold_full),
        .data  (hold_q)
    );

    uart_tx_parity #(.DATA_W(DATA_W)) par_i (
        .data (hold_q),
        .odd  (par_odd),
        .par  (par_bit)
    );

    uart_tx_fsm #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .hold_full (hold_full),
        .hold_data (hold_q),
        .par_en    (par_en),
        .par_bit   (par_bit),
        .xfer      (xfer),
        .sdo       (sdo),
        .busy      (busy)
    );

    assign tx_empty = ~busy;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic              wr_n,
    input logic              sdo,
    input logic              tx_empty,
    input logic              hold_full,
    input logic              xfer,
    input logic [DATA_W-1:0] hold_q
);
    AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && !hold_full) |=> hold_full); // R2

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> !sdo); // R3

    AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && !tx_empty) |=> $stable(sdo)); // R5

    AST_B2B_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !tx_empty) |=> !tx_empty); // R7

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> sdo); // R8

    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !xfer) |=> (hold_full && $stable(hold_q))); // R9

    AST_LOW_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wr_n) && !wr_n && !hold_full) |=> !hold_full); // R10
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .wr_n      (wr_n),
    .sdo       (sdo),
    .tx_empty  (tx_empty),
    .hold_full (hold_full),
    .xfer      (xfer),
    .hold_q    (hold_q)
);

// File: tb/uart_tx_dbuf_tb_top.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [7:0] din = 8'h00;
    logic       wr_n = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       sdo, tx_empty, hold_full;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_tx_dbuf dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .din(din), .wr_n(wr_n),
        .par_en(par_en), .par_odd(par_odd), .sdo(sdo), .tx_empty(tx_empty),
        .hold_full(hold_full)
    );

    // independent frame receiver plus tick generator
    int        tdiv = 0;
    bit        rx_act = 0;
    int        tcount = 0;
    bit        chg_seen = 0;
    logic [10:0] rbits;
    int        frames = 0;
    logic [7:0] r_data [32];
    logic       r_par [32];
    logic       r_stop [32];
    logic       r_empty [32];
    bit         r_b2b [33];
    int         r_first [32];
    bit         cur_b2b = 0;

    always @(negedge clk) begin
        int nb;
        nb = par_en ? 11 : 10;
        if (rst_n) begin
            if (rx_act) begin
                if (tick16) begin
                    tcount++;
                    if (tcount % 16 == 8) rbits[tcount/16] = sdo;
                end
                if (!chg_seen && sdo == 1'b1) begin
                    chg_seen = 1;
                    if (frames < 32) r_first[frames] = tcount;
                end
                if (tcount == 16*nb) begin
                    if (frames < 32) begin
                        r_data[frames]  = rbits[8:1];
                        r_par[frames]   = rbits[9];
                        r_stop[frames]  = rbits[nb-1];
                        r_empty[frames] = tx_empty;
                        r_b2b[frames]   = cur_b2b;
                    end
                    frames++;
                    if (sdo == 1'b0) begin
                        cur_b2b = 1; tcount = 0; chg_seen = 0;
                    end else begin
                        rx_act = 0;
                    end
                end
            end else if (sdo == 1'b0) begin
                rx_act = 1; tcount = 0; chg_seen = 0; cur_b2b = 0;
            end
        end
        tdiv = (tdiv + 1) % 4;
        tick16 = (tdiv == 0);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); din = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
    endtask

    task automatic wait_frames(input int n, input string req);
        int t;
        t = 0;
        while (frames < n && t < 5000) begin @(negedge clk); t++; end
        chk(req, frames, n);
    endtask

    // {par_en, par_odd, data}
    localparam logic [9:0] VEC [6] = '{
        {1'b1, 1'b0, 8'h56}, {1'b1, 1'b1, 8'h56}, {1'b0, 1'b0, 8'hA5},
        {1'b1, 1'b1, 8'h01}, {1'b1, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h80}
    };

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk("R1 sdo", sdo, 1); chk("R1 tx_empty", tx_empty, 1); chk("R1 hold_full", hold_full, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 sdo after release", sdo, 1);

        // table walk
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            d = VEC[i][7:0];
            @(negedge clk); par_en = VEC[i][9]; par_odd = VEC[i][8];
            write_byte(d);
            chk("R2 hold_full after write", hold_full, 1);
            chk("R2 tx_empty still high", tx_empty, 1);
            @(negedge clk);
            chk("R3 hold_full cleared", hold_full, 0);
            chk("R3 tx_empty low", tx_empty, 0);
            chk("R3 start bit", sdo, 0);
            wait_frames(i + 1, "R4 frame received");
            chk("R4 data LSB first", r_data[i], d);
            chk("R4 stop bit", r_stop[i], 1);
            if (VEC[i][9]) chk("R6 parity", r_par[i], (^d) ^ VEC[i][8]);
            if (d[0]) chk("R5 start bit 16 ticks", r_first[i], 16);
            chk("R8 tx_empty at frame end", r_empty[i], 1);
            repeat (20) @(negedge clk);
            chk("R8 idle high", sdo, 1);
        end

        // back to back, then a write while full
        @(negedge clk); par_en = 1'b0; par_odd = 1'b0;
        base = frames;
        write_byte(8'h3C);
        @(negedge clk);
        write_byte(8'hC3);
        chk("R7 second byte queued", hold_full, 1);
        write_byte(8'hFF);
        chk("R9 still full after ignored write", hold_full, 1);
        wait_frames(base + 2, "R7 two frames");
        chk("R7 first data", r_data[base], 8'h3C);
        chk("R9 queued byte sent", r_data[base+1], 8'hC3);
        chk("R7 no gap", r_b2b[base+1], 1);
        chk("R7 tx_empty low at boundary", r_empty[base], 0);
        repeat (1500) @(negedge clk);
        chk("R9 no extra frame", frames, base + 2);
        chk("R8 tx_empty high after", tx_empty, 1);
        chk("R8 sdo high after", sdo, 1);

        // strobe held low
        base = frames;
        @(negedge clk); din = 8'h81; wr_n = 1'b0;
        repeat (2000) @(negedge clk);
        wr_n = 1'b1;
        repeat (1500) @(negedge clk);
        chk("R10 single frame", frames, base + 1);
        chk("R10 data", r_data[base], 8'h81);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule